// File: doc/BRIEF.md
# Fractional Bit-Rate Tick Generator

This block derives a one-cycle bit-rate enable pulse from a fast system clock for a serial transmitter and receiver. A coarse integer prescaler divides the clock by (scale + 1). Each time the prescaler wraps, a fractional phase accumulator adds a programmable step. A tick is produced whenever that addition carries out of the top of the accumulator. The resulting tick rate is clk / (scale + 1) × step / 2^(STEP_W+1). With the default widths this is clk / (scale + 1) × step / 2^17.

Both fields arrive in one configuration word. The step sits in the low bits and the scale sits directly above it. A two-state controller governs the block:
- **IDLE**: the controller copies the configuration word into shadow registers on every clock and holds the counters at zero.
- **RUN**: the shadow copy is frozen and the prescaler and accumulator advance.

The transitions are:
- **IDLE→RUN** is taken on a clock where `en` is high. That edge is the last load of the shadow registers.
- **RUN→IDLE** is taken on a clock where `en` is low. That same edge clears all progress.
- **IDLE→IDLE** and **RUN→RUN** are the hold transitions.

A synchronous reset forces IDLE.

Top module: `frac_rate_gen`

## Requirements
- R1: While running, the prescaler wraps once every scale+1 clocks. On the m-th wrap after entering RUN, the accumulator holds m·step mod 2^17. A tick follows that wrap exactly when floor(m·step/2^17) exceeds floor((m−1)·step/2^17).
- R2: The step field is `cfg_word[15:0]` and the scale field is `cfg_word[23:16]`.
- R3: `tick` is high for exactly one clock. It goes high in the cycle after the clock edge whose accumulator addition carries out of bit 16, and at no other time.
- R4: While `rst` is high, `tick` is low and the block is in IDLE with the prescaler and accumulator at zero.
- R5: While `en` is low, no ticks are produced. A clock edge with `en` low clears the prescaler and accumulator, so a later enable starts from zero phase.
- R6: The configuration is captured at the clock edge that takes the block from IDLE to RUN. Changes to `cfg_word` while running have no effect on the ticks.
- R7: A step of zero produces no ticks for any scale.
- R8: Scale 0xFF with step 0xFFFF gives wraps every 256 clocks, with the first tick after the third wrap. Scale 0 with step 0xFFFF (the fastest setting) gives a tick on every other clock after the first two.
- R9: The controller moves IDLE→RUN on `en` high and RUN→IDLE on `en` low. The counters advance only in RUN with `en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low clears progress and allows configuration loading |
| cfg_word | input | 24 | Configuration word: scale in [23:16], step in [15:0] |
| tick | output | 1 | One-cycle bit-rate enable pulse |

## Verification
The bench builds the block with the default widths: an 8-bit scale, a 16-bit step and a 17-bit accumulator. These widths put both ends of the scale range within a short run. That covers a 256-clock prescaler at scale 0xFF and the every-other-clock fastest rate at scale 0. They also cover irregular fractional patterns such as step 0x5555, and the zero-step case.

The slowest setting, scale 0xFF with step 1, needs about 33 million clocks per tick. It is outside a short run, so only its no-early-tick behaviour is reachable.

Restart after a partial period and configuration changes made mid-run are exercised against tick positions computed from the rate formula.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rate_state_e;

endpackage

// File: rtl/frac_rate_ctrl.sv
module frac_rate_ctrl
    import frac_rate_pkg::*;
#(
    parameter int SCALE_W = 8,
    parameter int STEP_W  = 16,
    localparam int CFG_W  = SCALE_W + STEP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [CFG_W-1:0]   cfg_word,
    output logic [SCALE_W-1:0] scale_q,
    output logic [STEP_W-1:0]  step_q,
    output logic               active,
    output logic               running
);

    rate_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en)  state_d = ST_RUN;
            ST_RUN:  if (!en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running = (state_q == ST_RUN);
        active  = running && en;
    end

    // shadow configuration follows the word only while idle
    always_ff @(posedge clk) begin
        if (rst) begin
            scale_q <= '0;
            step_q  <= '0;
        end else if (state_q == ST_IDLE) begin
            scale_q <= cfg_word[CFG_W-1:STEP_W];
            step_q  <= cfg_word[STEP_W-1:0];
        end
    end

endmodule

// File: rtl/frac_rate_prescale.sv
module frac_rate_prescale #(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic [SCALE_W-1:0] limit,
    output logic [SCALE_W-1:0] count,
    output logic               wrap
);

    assign wrap = active && (count == limit);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            count <= '0;
        end else if (count == limit) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/frac_rate_phase.sv
module frac_rate_phase #(
    parameter int STEP_W = 16,
    localparam int ACC_W = STEP_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              add,
    input  logic [STEP_W-1:0] step,
    output logic              tick
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, acc_q} + {{(ACC_W + 1 - STEP_W){1'b0}}, step};

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= add && sum[ACC_W];
            if (add) begin
                acc_q <= sum[ACC_W-1:0];
            end
        end
    end

endmodule

// File: rtl/frac_rate_gen.sv
module frac_rate_gen #(
    parameter int SCALE_W = 8,
    parameter int STEP_W  = 16,
    localparam int CFG_W  = SCALE_W + STEP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             tick
);

    logic [SCALE_W-1:0] scale_q;
    logic [STEP_W-1:0]  step_q;
    logic [SCALE_W-1:0] pre_cnt;
    logic               active;
    logic               running;
    logic               wrap;

    frac_rate_ctrl #(.SCALE_W(SCALE_W), .STEP_W(STEP_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .cfg_word (cfg_word),
        .scale_q  (scale_q),
        .step_q   (step_q),
        .active   (active),
        .running  (running)
    );

    frac_rate_prescale #(.SCALE_W(SCALE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .limit  (scale_q),
        .count  (pre_cnt),
        .wrap   (wrap)
    );

    frac_rate_phase #(.STEP_W(STEP_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .add    (wrap),
        .step   (step_q),
        .tick   (tick)
    );

endmodule

// File: rtl/frac_rate_gen_chk.sv
module frac_rate_gen_chk #(
    parameter int SCALE_W = 8,
    parameter int STEP_W  = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               tick,
    input logic               running,
    input logic [SCALE_W-1:0] scale_q,
    input logic [STEP_W-1:0]  step_q,
    input logic [SCALE_W-1:0] pre_cnt
);

    // R4
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !tick);

    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tick);

    // R7
    zero_step_chk: assert property (@(posedge clk) disable iff (rst)
        (running && step_q == '0) |=> !tick);

    // R6
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |-> ($stable(scale_q) && $stable(step_q)));

    // R1
    pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pre_cnt <= scale_q);

endmodule

bind frac_rate_gen frac_rate_gen_chk #(.SCALE_W(SCALE_W), .STEP_W(STEP_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .tick    (tick),
    .running (running),
    .scale_q (scale_q),
    .step_q  (step_q),
    .pre_cnt (pre_cnt)
);

// File: tb/frac_rate_gen_tb_top.sv
module frac_rate_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [23:0] cfg = '0;
    logic        tick;

    always #4 clk = ~clk;

    frac_rate_gen #(.SCALE_W(8), .STEP_W(16)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .cfg_word (cfg),
        .tick     (tick)
    );

    int    cyc = 0;
    int    exp_q[$];
    string cur_req = "R4";
    int    checks = 0;
    int    errors = 0;
    int    seen = 0;
    bit    prev_tick = 1'b0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected tick cycles and compares (R1, R3)
    always @(negedge clk) begin
        if (!rst) begin
            while (exp_q.size() > 0 && exp_q[0] < cyc) begin
                errors++;
                $display("FAIL %s R3: no tick at cycle %0d, actual 0, expected 1", cur_req, exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (tick) begin
                seen++;
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    checks++;
                    void'(exp_q.pop_front());
                end else begin
                    errors++;
                    $display("FAIL %s R3: tick at cycle %0d, actual 1, expected 0", cur_req, cyc);
                end
                if (prev_tick) begin
                    errors++;
                    $display("FAIL R3: tick held two cycles at %0d, actual 1, expected 0", cyc);
                end
            end
        end
        prev_tick = tick;
    end

    task automatic finish_run(input string req, input int expn);
        checks++;
        if (seen != expn) begin
            errors++;
            $display("FAIL %s: tick count actual %0d, expected %0d", req, seen, expn);
        end
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: pending ticks actual %0d, expected 0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    // driver: enables with a config, pushes expected tick cycles from the formula (R1, R2)
    task automatic run_cfg(input int s, input int p, input int n, input bit poke, input string req);
        int c0;
        int expn;
        @(negedge clk);
        cur_req = req;
        seen = 0;
        expn = 0;
        cfg = {s[7:0], p[15:0]};
        en = 1'b1;
        c0 = cyc + 1;
        for (int k = 1; k < n; k++) begin
            if (k % (s + 1) == 0) begin
                longint m = k / (s + 1);
                if (((m * p) >> 17) != (((m - 1) * p) >> 17)) begin
                    exp_q.push_back(c0 + k);
                    expn++;
                end
            end
        end
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (poke && i == n / 2) cfg = ~cfg;   // R6: ignored while running
        end
        en = 1'b0;
        repeat (4) @(negedge clk);
        finish_run(req, expn);
    endtask

    initial begin
        // R4: reset holds tick low even with a fast config and enable
        cfg = {8'd0, 16'hFFFF};
        en  = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            checks++;
            if (tick !== 1'b0) begin
                errors++;
                $display("FAIL R4: tick during reset actual %b, expected 0", tick);
            end
        end
        en = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // R5: disabled with a fast config produces nothing
        cur_req = "R5";
        seen = 0;
        repeat (20) @(negedge clk);
        finish_run("R5", 0);

        run_cfg(3, 32'h8000, 70, 1'b0, "R1");
        run_cfg(2, 32'h5555, 200, 1'b0, "R2");
        run_cfg(0, 32'hFFFF, 40, 1'b0, "R8");
        run_cfg(255, 32'hFFFF, 1100, 1'b0, "R8");
        run_cfg(5, 0, 300, 1'b0, "R7");
        run_cfg(1, 32'h6000, 120, 1'b1, "R6");
        // R5 / R9: partial period then restart must begin from zero phase
        run_cfg(0, 32'h8000, 7, 1'b0, "R9");
        run_cfg(0, 32'h8000, 30, 1'b0, "R5");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, actual timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule